// File: doc/BRIEF.md
# Order-Preserving Shared Memory Arbiter

This block sits in front of a single data-cache port that three requesters share: the vector load/store unit, the scalar core's data port and the scalar core's instruction fetch. Each cycle it picks at most one requester, routes that requester's address, write flag and write data to the cache, and reports the choice with a one-hot grant. Priority is fixed. The vector unit ranks first, the scalar data port second and the fetch port last. Once a grant is given, it is held until the cache takes the request, so no requester is ever pre-empted.

Global memory order is protected by a hold that a miss starts. The block keeps an up/down count of vector accesses that the cache has accepted but that are not yet complete. A vector acceptance raises the count and a completion pulse lowers it. If a scalar access misses while that count is nonzero, every later scalar access is blocked until the count returns to zero. The vector unit is not blocked during the hold. The hold always ends, because the vector unit gets no new work while the scalar core is stalled.

The cache reports hit or miss in the same cycle in which it accepts a request. The arbiter uses that flag only as an input.

Top module: `mem_order_arb`

## Requirements
- R1: After reset, with no request valid, `grant_o` is 0 and `cache_valid_o` is 0.
- R2: When no grant is held over from an earlier cycle, a valid vector request is granted (`grant_o` bit 0) even if either scalar request is also valid.
- R3: When no grant is held over, no vector request is valid and no hold is active, a valid scalar data request (`grant_o` bit 1) wins over a valid fetch request (`grant_o` bit 2).
- R4: `grant_o` is at most one-hot. A grant that the cache does not accept (`cache_ready_i` low) stays on the same requester in the next cycle, even if a higher-priority request has arrived.
- R5: If a scalar access is accepted with `cache_miss_i` high while the pending vector count (after this cycle's update) is nonzero, no scalar request is granted from the next cycle onward. Scalar grants become possible again in the cycle after the one in which the count reaches zero.
- R6: While scalar requests are held by R5, vector requests are still granted and accepted.
- R7: A scalar miss accepted while no vector access is pending starts no hold: the next scalar request is granted in the following cycle.
- R8: A scalar access accepted with `cache_miss_i` low starts no hold, even when vector accesses are pending.
- R9: The cache channel carries the granted requester's address, write flag and write data, and a source code of 0 for vector, 1 for scalar data and 2 for fetch. A fetch is a read with zero write data. A requester's ready output is high exactly when that requester is granted and `cache_ready_i` is high.
- R10: The order in which the cache accepts accesses follows the priority and hold rules above across all three requesters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_valid_i | input | 1 | Vector load/store request valid |
| vec_addr_i | input | ADDR_W | Vector request address |
| vec_we_i | input | 1 | Vector request is a store |
| vec_wdata_i | input | DATA_W | Vector store data |
| vec_ready_o | output | 1 | Vector request accepted this cycle |
| vec_done_i | input | 1 | Pulse: one accepted vector access has completed |
| sd_valid_i | input | 1 | Scalar data request valid |
| sd_addr_i | input | ADDR_W | Scalar data address |
| sd_we_i | input | 1 | Scalar data request is a store |
| sd_wdata_i | input | DATA_W | Scalar store data |
| sd_ready_o | output | 1 | Scalar data request accepted this cycle |
| if_valid_i | input | 1 | Instruction fetch request valid |
| if_addr_i | input | ADDR_W | Fetch address |
| if_ready_o | output | 1 | Fetch request accepted this cycle |
| cache_valid_o | output | 1 | Request to the cache valid |
| cache_addr_o | output | ADDR_W | Address to the cache |
| cache_we_o | output | 1 | Write flag to the cache |
| cache_wdata_o | output | DATA_W | Write data to the cache |
| cache_src_o | output | 2 | Source code of the request (0 vector, 1 data, 2 fetch) |
| cache_ready_i | input | 1 | Cache accepts the presented request |
| cache_miss_i | input | 1 | The request accepted this cycle missed |
| grant_o | output | 3 | One-hot grant: bit 0 vector, bit 1 data, bit 2 fetch |

## Verification
The bench first makes all three requesters compete at once and checks that the vector, data and fetch accesses come out in that order. A design with the two scalar ranks swapped would send the fetch out ahead of the data access. It then holds the cache stalled while a vector request arrives behind a pending fetch grant. A design that pre-empts would switch the grant to the vector unit and let that access go first. Next it starts a scalar miss with one vector access pending, leaves later scalar requests waiting and brings in a new vector request. A design that ignores the hold would let a scalar access pass the vector access. A design that holds the vector unit as well would stop altogether. A design that releases the hold one cycle early would grant the scalar access in the same cycle as the last completion. Finally, a miss with nothing pending and a hit with a vector access pending must both let the next scalar access through at once. A design that holds too eagerly would stall in both cases.

// File: rtl/mem_arb_pkg.sv
// Shared constants and the source encoding used by the memory arbiter.
// Assumes requester index 0 is the highest priority.
package mem_arb_pkg;
    localparam int NUM_REQ = 3;
    localparam int SRC_W   = $clog2(NUM_REQ);

    typedef enum logic [SRC_W-1:0] {
        SRC_VEC   = 2'd0,
        SRC_DATA  = 2'd1,
        SRC_FETCH = 2'd2
    } src_e;
endpackage

// File: rtl/mem_arb_pick.sv
// Fixed-priority picker with a grant lock. Index 0 wins. A grant that is not
// accepted by the cache is kept on the same requester in the next cycle.
// Assumes a requester keeps its valid high until it is accepted.
module mem_arb_pick #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] elig_i,
    input  logic         take_i,
    output logic [N-1:0] grant_o
);
    logic [N-1:0] cand;
    logic [N-1:0] first;
    logic [N:0]   seen;
    logic         locked_q;
    logic [N-1:0] lock_gnt_q;

    assign cand    = req_i & elig_i;
    assign seen[0] = 1'b0;

    // Priority chain: a candidate wins if no lower index is a candidate.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign first[i]    = cand[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | cand[i];
    end

    // A held grant overrides a new pick.
    assign grant_o = locked_q ? lock_gnt_q : first;

    // Remember an unaccepted grant for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q   <= 1'b0;
            lock_gnt_q <= '0;
        end else begin
            locked_q   <= (|grant_o) & ~take_i;
            lock_gnt_q <= grant_o;
        end
    end

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_grant_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && !take_i) |=> (grant_o == $past(grant_o)));
endmodule

// File: rtl/mem_arb_vec_track.sv
// Counts vector accesses that were accepted but are not complete, and holds
// scalar traffic after a scalar miss until that count reaches zero.
// Assumes completions never exceed acceptances and the count fits PEND_W.
module mem_arb_vec_track #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    input  logic scalar_miss_i,
    output logic hold_o
);
    localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] cnt_q;
    logic [PEND_W-1:0] cnt_d;
    logic              hold_q;

    // Next pending count after this cycle's acceptance and completion.
    always_comb begin
        cnt_d = cnt_q + PEND_W'(inc_i) - PEND_W'(dec_i);
    end

    // Count register and the miss-started hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            hold_q <= (hold_q | scalar_miss_i) & (cnt_d != '0);
        end
    end

    assign hold_o = hold_q;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |-> !(inc_i && !dec_i));

    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !(dec_i && !inc_i));

    p_hold_needs_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (cnt_q != '0));
endmodule

// File: rtl/mem_arb_mux.sv
// AND-OR multiplexer that steers the granted requester's fields to the
// cache and encodes the grant as a source index. Assumes a one-hot grant.
module mem_arb_mux #(
    parameter int N      = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [N-1:0]             grant_i,
    input  logic [N-1:0][ADDR_W-1:0] addr_i,
    input  logic [N-1:0]             we_i,
    input  logic [N-1:0][DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic                     we_o,
    output logic [DATA_W-1:0]        wdata_o,
    output logic [$clog2(N)-1:0]     src_o
);
    localparam int SW = $clog2(N);

    // Merge the fields of the granted requester.
    always_comb begin
        addr_o  = '0;
        we_o    = 1'b0;
        wdata_o = '0;
        src_o   = '0;
        for (int i = 0; i < N; i++) begin
            addr_o  = addr_o  | (addr_i[i]  & {ADDR_W{grant_i[i]}});
            wdata_o = wdata_o | (wdata_i[i] & {DATA_W{grant_i[i]}});
            we_o    = we_o    | (we_i[i] & grant_i[i]);
            src_o   = src_o   | (SW'(i) & {SW{grant_i[i]}});
        end
    end
endmodule

// File: rtl/mem_order_arb.sv
// Order-preserving arbiter for one shared cache port. The vector unit has
// the highest priority, then scalar data, then fetch. A scalar miss with
// vector accesses pending holds scalar traffic until those complete.
// Assumes requesters keep valid and fields stable until accepted.
module mem_order_arb #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid_i,
    input  logic [ADDR_W-1:0] vec_addr_i,
    input  logic              vec_we_i,
    input  logic [DATA_W-1:0] vec_wdata_i,
    output logic              vec_ready_o,
    input  logic              vec_done_i,
    input  logic              sd_valid_i,
    input  logic [ADDR_W-1:0] sd_addr_i,
    input  logic              sd_we_i,
    input  logic [DATA_W-1:0] sd_wdata_i,
    output logic              sd_ready_o,
    input  logic              if_valid_i,
    input  logic [ADDR_W-1:0] if_addr_i,
    output logic              if_ready_o,
    output logic              cache_valid_o,
    output logic [ADDR_W-1:0] cache_addr_o,
    output logic              cache_we_o,
    output logic [DATA_W-1:0] cache_wdata_o,
    output logic [1:0]        cache_src_o,
    input  logic              cache_ready_i,
    input  logic              cache_miss_i,
    output logic [2:0]        grant_o
);
    import mem_arb_pkg::*;

    logic [NUM_REQ-1:0]             req;
    logic [NUM_REQ-1:0]             elig;
    logic [NUM_REQ-1:0]             grant;
    logic [NUM_REQ-1:0][ADDR_W-1:0] addr_arr;
    logic [NUM_REQ-1:0][DATA_W-1:0] wdata_arr;
    logic [NUM_REQ-1:0]             we_arr;
    logic [SRC_W-1:0]               src;
    logic                           hold;
    logic                           take;
    logic                           scalar_miss;

    // Gather requester channels into index order (0 = highest priority).
    assign req       = {if_valid_i, sd_valid_i, vec_valid_i};
    assign addr_arr  = {if_addr_i, sd_addr_i, vec_addr_i};
    assign wdata_arr = {{DATA_W{1'b0}}, sd_wdata_i, vec_wdata_i};
    assign we_arr    = {1'b0, sd_we_i, vec_we_i};
    assign elig      = {~hold, ~hold, 1'b1};

    mem_arb_pick #(.N(NUM_REQ)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .elig_i  (elig),
        .take_i  (cache_ready_i),
        .grant_o (grant)
    );

    mem_arb_mux #(.N(NUM_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .grant_i (grant),
        .addr_i  (addr_arr),
        .we_i    (we_arr),
        .wdata_i (wdata_arr),
        .addr_o  (cache_addr_o),
        .we_o    (cache_we_o),
        .wdata_o (cache_wdata_o),
        .src_o   (src)
    );

    // Acceptance and scalar-miss detection for the tracker.
    assign take        = (|grant) & cache_ready_i;
    assign scalar_miss = take & ~grant[SRC_VEC] & cache_miss_i;

    mem_arb_vec_track #(.PEND_W(PEND_W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .inc_i         (vec_ready_o),
        .dec_i         (vec_done_i),
        .scalar_miss_i (scalar_miss),
        .hold_o        (hold)
    );

    // Port outputs.
    assign grant_o       = grant;
    assign cache_valid_o = |grant;
    assign cache_src_o   = src;
    assign vec_ready_o   = grant[SRC_VEC]   & cache_ready_i;
    assign sd_ready_o    = grant[SRC_DATA]  & cache_ready_i;
    assign if_ready_o    = grant[SRC_FETCH] & cache_ready_i;

    p_vec_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_i && !$past(cache_valid_o && !cache_ready_i)) |-> grant_o[0]);

    p_data_over_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_valid_i && if_valid_i && !vec_valid_i && !hold
         && !$past(cache_valid_o && !cache_ready_i)) |-> !grant_o[2]);

    p_hold_blocks_scalar_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(grant_o[1] || grant_o[2]));

    p_vec_free_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && vec_valid_i && !$past(cache_valid_o && !cache_ready_i)) |-> grant_o[0]);
endmodule

// File: tb/mem_order_arb_tb.sv
module mem_order_arb_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vec_valid_i, vec_we_i, vec_ready_o, vec_done_i;
    logic [31:0] vec_addr_i, vec_wdata_i;
    logic        sd_valid_i, sd_we_i, sd_ready_o;
    logic [31:0] sd_addr_i, sd_wdata_i;
    logic        if_valid_i, if_ready_o;
    logic [31:0] if_addr_i;
    logic        cache_valid_o, cache_we_o, cache_ready_i, cache_miss_i;
    logic [31:0] cache_addr_o, cache_wdata_o;
    logic [1:0]  cache_src_o;
    logic [2:0]  grant_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] vq[$];
    logic [31:0] dq[$];
    logic [31:0] fq[$];
    logic [66:0] expq[$];   // {src[1:0], we, addr[31:0], wdata[31:0]}

    logic [2:0]  s_grant;
    logic        s_cvalid, s_vrdy, s_drdy, s_frdy;

    always #4 clk = ~clk;   // 125 MHz

    mem_order_arb u_dut (
        .clk(clk), .rst_n(rst_n),
        .vec_valid_i(vec_valid_i), .vec_addr_i(vec_addr_i), .vec_we_i(vec_we_i),
        .vec_wdata_i(vec_wdata_i), .vec_ready_o(vec_ready_o), .vec_done_i(vec_done_i),
        .sd_valid_i(sd_valid_i), .sd_addr_i(sd_addr_i), .sd_we_i(sd_we_i),
        .sd_wdata_i(sd_wdata_i), .sd_ready_o(sd_ready_o),
        .if_valid_i(if_valid_i), .if_addr_i(if_addr_i), .if_ready_o(if_ready_o),
        .cache_valid_o(cache_valid_o), .cache_addr_o(cache_addr_o),
        .cache_we_o(cache_we_o), .cache_wdata_o(cache_wdata_o),
        .cache_src_o(cache_src_o), .cache_ready_i(cache_ready_i),
        .cache_miss_i(cache_miss_i), .grant_o(grant_o)
    );

    function automatic logic [31:0] wd(input logic [31:0] a);
        return a ^ 32'h5A5A_5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input logic [66:0] act,
                         input logic [66:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_item(input logic [1:0] src, input logic [31:0] a);
        logic we;
        logic [31:0] d;
        we = (src == 2'd0) ? a[0] : (src == 2'd1) ? a[1] : 1'b0;
        d  = (src == 2'd2) ? 32'h0 : wd(a);
        expq.push_back({src, we, a, d});
    endtask

    // Driver: one cycle of requester activity, then sample and retire.
    task automatic step(input logic rdy, input logic miss, input logic done);
        @(negedge clk);
        vec_valid_i   = (vq.size() > 0);
        vec_addr_i    = (vq.size() > 0) ? vq[0] : 32'h0;
        vec_we_i      = vec_addr_i[0];
        vec_wdata_i   = wd(vec_addr_i);
        sd_valid_i    = (dq.size() > 0);
        sd_addr_i     = (dq.size() > 0) ? dq[0] : 32'h0;
        sd_we_i       = sd_addr_i[1];
        sd_wdata_i    = wd(sd_addr_i);
        if_valid_i    = (fq.size() > 0);
        if_addr_i     = (fq.size() > 0) ? fq[0] : 32'h0;
        cache_ready_i = rdy;
        cache_miss_i  = miss;
        vec_done_i    = done;
        #3;
        s_grant  = grant_o;
        s_cvalid = cache_valid_o;
        s_vrdy   = vec_ready_o;
        s_drdy   = sd_ready_o;
        s_frdy   = if_ready_o;
        if (s_vrdy) void'(vq.pop_front());
        if (s_drdy) void'(dq.pop_front());
        if (s_frdy) void'(fq.pop_front());
    endtask

    // Monitor: compare every accepted cache access against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n === 1'b1 && cache_valid_o && cache_ready_i) begin
                if (expq.size() == 0) begin
                    check(0, "R10 unexpected access",
                          {cache_src_o, cache_we_o, cache_addr_o, cache_wdata_o}, 67'h0);
                end else begin
                    logic [66:0] e;
                    e = expq.pop_front();
                    check({cache_src_o, cache_we_o, cache_addr_o, cache_wdata_o} == e,
                          "R9/R10 access fields and order",
                          {cache_src_o, cache_we_o, cache_addr_o, cache_wdata_o}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        vec_valid_i = 0; vec_addr_i = 0; vec_we_i = 0; vec_wdata_i = 0; vec_done_i = 0;
        sd_valid_i = 0; sd_addr_i = 0; sd_we_i = 0; sd_wdata_i = 0;
        if_valid_i = 0; if_addr_i = 0; cache_ready_i = 0; cache_miss_i = 0;
        repeat (3) step(1, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset.
        step(1, 0, 0);
        check(s_grant == 3'b000 && !s_cvalid, "R1 idle after reset",
              {64'h0, s_grant}, 67'h0);

        // Scenario A: all three compete (R2, R3, R10).
        vq.push_back(32'h1000); vq.push_back(32'h1001);
        dq.push_back(32'h2002); fq.push_back(32'h3000);
        expect_item(2'd0, 32'h1000); expect_item(2'd0, 32'h1001);
        expect_item(2'd1, 32'h2002); expect_item(2'd2, 32'h3000);
        step(1, 0, 0);
        check(s_grant == 3'b001, "R2 vector wins", {64'h0, s_grant}, 67'h1);
        check(s_vrdy && !s_drdy && !s_frdy, "R9 ready follows grant",
              {64'h0, s_vrdy, s_drdy, s_frdy}, 67'h4);
        step(1, 0, 0);
        step(1, 0, 0);
        check(s_grant == 3'b010, "R3 data over fetch", {64'h0, s_grant}, 67'h2);
        step(1, 0, 0);
        check(s_grant == 3'b100 && s_frdy, "R10 fetch last", {64'h0, s_grant}, 67'h4);
        step(1, 0, 1);
        step(1, 0, 1);

        // Scenario B: held grant survives a vector arrival (R4).
        fq.push_back(32'h3004);
        expect_item(2'd2, 32'h3004); expect_item(2'd0, 32'h1010);
        step(0, 0, 0);
        check(s_grant == 3'b100 && s_cvalid, "R4 fetch granted", {64'h0, s_grant}, 67'h4);
        vq.push_back(32'h1010);
        step(0, 0, 0);
        check(s_grant == 3'b100, "R4 no pre-emption by vector", {64'h0, s_grant}, 67'h4);
        step(1, 0, 0);
        check(s_frdy && !s_vrdy, "R4 held fetch accepted first",
              {65'h0, s_frdy, s_vrdy}, 67'h2);
        step(1, 0, 0);
        check(s_vrdy, "R4 vector follows", {66'h0, s_vrdy}, 67'h1);
        // One vector access now pending.

        // Scenario C: scalar miss with vector pending (R5, R6).
        dq.push_back(32'h2010);
        expect_item(2'd1, 32'h2010); expect_item(2'd0, 32'h1020);
        expect_item(2'd1, 32'h2014); expect_item(2'd2, 32'h3008);
        step(1, 1, 0);
        check(s_drdy, "R5 missing access accepted", {66'h0, s_drdy}, 67'h1);
        dq.push_back(32'h2014); fq.push_back(32'h3008);
        for (int k = 0; k < 3; k++) begin
            step(1, 0, 0);
            check(!s_cvalid && s_grant == 3'b000, "R5 scalar held",
                  {64'h0, s_grant}, 67'h0);
        end
        vq.push_back(32'h1020);
        step(1, 0, 0);
        check(s_vrdy && s_grant == 3'b001, "R6 vector runs during hold",
              {64'h0, s_grant}, 67'h1);
        step(1, 0, 1);
        check(!s_cvalid, "R5 held with one pending", {66'h0, s_cvalid}, 67'h0);
        step(1, 0, 1);
        check(!s_cvalid, "R5 held in cycle of last completion", {66'h0, s_cvalid}, 67'h0);
        step(1, 0, 0);
        check(s_drdy, "R5 released after count reaches zero", {66'h0, s_drdy}, 67'h1);
        step(1, 0, 0);
        check(s_frdy, "R5 fetch after release", {66'h0, s_frdy}, 67'h1);

        // Scenario D: miss with nothing pending (R7).
        dq.push_back(32'h2020); dq.push_back(32'h2024);
        expect_item(2'd1, 32'h2020); expect_item(2'd1, 32'h2024);
        step(1, 1, 0);
        step(1, 0, 0);
        check(s_drdy, "R7 no hold without pending vector", {66'h0, s_drdy}, 67'h1);

        // Scenario E: hit with vector pending (R8).
        vq.push_back(32'h1031);
        dq.push_back(32'h2030); dq.push_back(32'h2036);
        expect_item(2'd0, 32'h1031); expect_item(2'd1, 32'h2030);
        expect_item(2'd1, 32'h2036);
        step(1, 0, 0);
        step(1, 0, 0);
        check(s_drdy, "R8 first hit accepted", {66'h0, s_drdy}, 67'h1);
        step(1, 0, 0);
        check(s_drdy, "R8 hit starts no hold", {66'h0, s_drdy}, 67'h1);
        step(1, 0, 1);
        step(1, 0, 0);
        check(!s_cvalid, "R1 idle at end", {66'h0, s_cvalid}, 67'h0);

        check(expq.size() == 0, "R10 all expected accesses seen",
              67'(expq.size()), 67'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule